// File: doc/BRIEF.md
# Fast Context Shadow for Interrupt and Subroutine Entry

This block keeps one saved copy of three core registers: a 5-bit status register, an 8-bit working register and a 4-bit bank select register. The core pulses an event strobe when it vectors to an interrupt, when it executes a subroutine call, when it executes a subroutine return, or when it executes an interrupt return. A separate `fast` qualifier marks whether the call or return uses the quick context option. Interrupt entry always saves. A call saves only when it is marked fast. Either kind of return restores only when it is marked fast.

A restore presents all three saved values on the restore outputs, one clock after the return strobe. A one-cycle valid pulse comes with them, so the core can load all three live registers on the same edge. There is only one saved level, and a later save replaces an earlier one without any warning. For example, an interrupt taken inside another interrupt's handler destroys the outer context. The saved copy cannot be read or written by software. It is reached only through the restore path.

Top module: `ctx_shadow`

## Requirements
- R1: After reset the restore outputs are zero and the valid strobe is low. The saved copy is also zero, so a fast return issued before any save restores all-zero values.
- R2: An interrupt-entry strobe saves the present status, working and bank values. This happens whatever the level of the fast qualifier.
- R3: A call strobe with the fast qualifier high saves the three live values. A call strobe with the fast qualifier low leaves the saved copy unchanged.
- R4: A return strobe with the fast qualifier high raises the restore valid strobe in the next cycle. In that cycle the restore outputs carry the saved values.
- R5: An interrupt-return strobe with the fast qualifier high restores the same way as R4.
- R6: A return or interrupt-return strobe with the fast qualifier low produces no valid strobe. It does not change the restore outputs or the saved copy.
- R7: The valid strobe is high for exactly one cycle per restoring event. While it is low, the restore outputs keep the last restored values.
- R8: With one level only, a second save replaces the first. A later restore returns the most recent save.
- R9: When a save and a restore happen in the same cycle, the restore returns the contents from before that cycle. The saved copy then holds the new live values.
- R10: A restore does not consume the saved copy. Two fast returns in a row restore the same values, with a valid pulse in each of the two following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_status | input | STAT_W (5) | Current status register value |
| live_wreg | input | WREG_W (8) | Current working register value |
| live_bank | input | BANK_W (4) | Current bank select value |
| ev_irq_entry | input | 1 | Core is vectoring to an interrupt |
| ev_call | input | 1 | Subroutine call strobe |
| ev_ret | input | 1 | Subroutine return strobe |
| ev_reti | input | 1 | Interrupt return strobe |
| opt_fast | input | 1 | Fast qualifier for the call or return in this cycle |
| rest_status | output | STAT_W (5) | Restored status value |
| rest_wreg | output | WREG_W (8) | Restored working register value |
| rest_bank | output | BANK_W (4) | Restored bank select value |
| rest_valid | output | 1 | One-cycle pulse marking a restore |

## Verification
The bench builds the block with its default widths: 5, 8 and 4 bits. At these widths, all-zero, all-ones and alternating-bit patterns fit in every field, so a field swapped or truncated in the restore path shows up as a mismatch. The stimulus covers these sequences:
- saves with the fast qualifier both high and low;
- nested saves;
- a save and a restore in the same cycle;
- back-to-back restores.

Together these reach the ordering cases of R8 to R10, where a one-deep copy is most likely to go wrong.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;

    // Action chosen for one cycle by the event decoder.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_SAVE = 2'b01,
        ACT_LOAD = 2'b10,
        ACT_BOTH = 2'b11
    } ctx_act_e;

    function automatic logic act_saves(input ctx_act_e a);
        return (a == ACT_SAVE) || (a == ACT_BOTH);
    endfunction

    function automatic logic act_loads(input ctx_act_e a);
        return (a == ACT_LOAD) || (a == ACT_BOTH);
    endfunction

endpackage

// File: rtl/ctx_shadow_decode.sv
module ctx_shadow_decode
    import ctx_shadow_pkg::*;
(
    input  logic     ev_irq_entry,
    input  logic     ev_call,
    input  logic     ev_ret,
    input  logic     ev_reti,
    input  logic     opt_fast,
    output ctx_act_e act
);
    logic save_req;
    logic load_req;

    always_comb begin
        // Interrupt entry saves unconditionally; a call saves only when fast.
        save_req = ev_irq_entry || (ev_call && opt_fast);
        // Both return kinds restore only when fast.
        load_req = (ev_ret || ev_reti) && opt_fast;
        unique case ({load_req, save_req})
            2'b01:   act = ACT_SAVE;
            2'b10:   act = ACT_LOAD;
            2'b11:   act = ACT_BOTH;
            default: act = ACT_IDLE;
        endcase
    end
endmodule

// File: rtl/ctx_shadow_store.sv
module ctx_shadow_store
    import ctx_shadow_pkg::*;
#(
    parameter int CTX_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctx_act_e         act,
    input  logic [CTX_W-1:0] live_ctx,
    output logic [CTX_W-1:0] held_ctx
);
    typedef struct packed {
        logic [CTX_W-1:0] ctx;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_saves(act)) begin
            st_d.ctx = live_ctx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_ctx = st_q.ctx;
endmodule

// File: rtl/ctx_shadow_restore.sv
module ctx_shadow_restore
    import ctx_shadow_pkg::*;
#(
    parameter int CTX_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctx_act_e         act,
    input  logic [CTX_W-1:0] held_ctx,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_vld
);
    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic             vld;
    } rest_t;

    rest_t rs_d, rs_q;

    always_comb begin
        rs_d     = rs_q;
        rs_d.vld = 1'b0;
        if (act_loads(act)) begin
            // Reads the copy from before this cycle's save.
            rs_d.ctx = held_ctx;
            rs_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign out_ctx = rs_q.ctx;
    assign out_vld = rs_q.vld;
endmodule

// File: rtl/ctx_shadow.sv
module ctx_shadow
    import ctx_shadow_pkg::*;
#(
    parameter int STAT_W = 5,
    parameter int WREG_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] live_status,
    input  logic [WREG_W-1:0] live_wreg,
    input  logic [BANK_W-1:0] live_bank,
    input  logic              ev_irq_entry,
    input  logic              ev_call,
    input  logic              ev_ret,
    input  logic              ev_reti,
    input  logic              opt_fast,
    output logic [STAT_W-1:0] rest_status,
    output logic [WREG_W-1:0] rest_wreg,
    output logic [BANK_W-1:0] rest_bank,
    output logic              rest_valid
);
    localparam int CTX_W = STAT_W + WREG_W + BANK_W;

    ctx_act_e         act;
    logic [CTX_W-1:0] live_ctx;
    logic [CTX_W-1:0] held_ctx;
    logic [CTX_W-1:0] out_ctx;

    assign live_ctx = {live_status, live_wreg, live_bank};

    ctx_shadow_decode i_decode (
        .ev_irq_entry (ev_irq_entry),
        .ev_call      (ev_call),
        .ev_ret       (ev_ret),
        .ev_reti      (ev_reti),
        .opt_fast     (opt_fast),
        .act          (act)
    );

    ctx_shadow_store #(.CTX_W(CTX_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .live_ctx (live_ctx),
        .held_ctx (held_ctx)
    );

    ctx_shadow_restore #(.CTX_W(CTX_W)) i_restore (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .held_ctx (held_ctx),
        .out_ctx  (out_ctx),
        .out_vld  (rest_valid)
    );

    assign {rest_status, rest_wreg, rest_bank} = out_ctx;
endmodule

// File: rtl/ctx_shadow_chk.sv
module ctx_shadow_chk #(
    parameter int STAT_W = 5,
    parameter int WREG_W = 8,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] live_status,
    input logic [WREG_W-1:0] live_wreg,
    input logic [BANK_W-1:0] live_bank,
    input logic              ev_irq_entry,
    input logic              ev_call,
    input logic              ev_ret,
    input logic              ev_reti,
    input logic              opt_fast,
    input logic [STAT_W-1:0] rest_status,
    input logic [WREG_W-1:0] rest_wreg,
    input logic [BANK_W-1:0] rest_bank,
    input logic              rest_valid
);
    logic do_save;
    logic do_load;
    assign do_save = ev_irq_entry || (ev_call && opt_fast);
    assign do_load = (ev_ret || ev_reti) && opt_fast;

    AST_LOAD_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> rest_valid);                                          // R4

    AST_NO_FAST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> !rest_valid);                                        // R6

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rest_valid |-> $stable({rest_status, rest_wreg, rest_bank}));    // R7

    AST_SAVE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_save ##1 do_load) |=>
            ({rest_status, rest_wreg, rest_bank} ==
             $past({live_status, live_wreg, live_bank}, 2)));             // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!rest_valid && rest_status == '0 &&
                    rest_wreg == '0 && rest_bank == '0));                 // R1
endmodule

bind ctx_shadow ctx_shadow_chk #(
    .STAT_W(STAT_W), .WREG_W(WREG_W), .BANK_W(BANK_W)
) i_ctx_shadow_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .live_status  (live_status),
    .live_wreg    (live_wreg),
    .live_bank    (live_bank),
    .ev_irq_entry (ev_irq_entry),
    .ev_call      (ev_call),
    .ev_ret       (ev_ret),
    .ev_reti      (ev_reti),
    .opt_fast     (opt_fast),
    .rest_status  (rest_status),
    .rest_wreg    (rest_wreg),
    .rest_bank    (rest_bank),
    .rest_valid   (rest_valid)
);

// File: tb/test_ctx_shadow.sv
`timescale 1ns/1ps
module test_ctx_shadow;
    localparam int SW = 5;
    localparam int WW = 8;
    localparam int BW = 4;

    typedef struct {
        int          cyc;
        logic [SW-1:0] st;
        logic [WW-1:0] w;
        logic [BW-1:0] b;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] live_status = '0;
    logic [WW-1:0] live_wreg = '0;
    logic [BW-1:0] live_bank = '0;
    logic          ev_irq_entry = 1'b0;
    logic          ev_call = 1'b0;
    logic          ev_ret = 1'b0;
    logic          ev_reti = 1'b0;
    logic          opt_fast = 1'b0;
    logic [SW-1:0] rest_status;
    logic [WW-1:0] rest_wreg;
    logic [BW-1:0] rest_bank;
    logic          rest_valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    item_t exp_q[$];
    logic [SW-1:0] m_st = '0;
    logic [WW-1:0] m_w  = '0;
    logic [BW-1:0] m_b  = '0;
    logic [SW-1:0] last_st = '0;
    logic [WW-1:0] last_w  = '0;
    logic [BW-1:0] last_b  = '0;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    ctx_shadow i_ctx_shadow (
        .clk(clk), .rst_n(rst_n),
        .live_status(live_status), .live_wreg(live_wreg), .live_bank(live_bank),
        .ev_irq_entry(ev_irq_entry), .ev_call(ev_call), .ev_ret(ev_ret),
        .ev_reti(ev_reti), .opt_fast(opt_fast),
        .rest_status(rest_status), .rest_wreg(rest_wreg), .rest_bank(rest_bank),
        .rest_valid(rest_valid)
    );

    task automatic check(input bit ok, input string req, input string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Driver: applies one cycle of stimulus and predicts the restore.
    task automatic drive(input bit irq, input bit call, input bit ret,
                         input bit reti, input bit fast,
                         input logic [SW-1:0] st, input logic [WW-1:0] w,
                         input logic [BW-1:0] b, input string req);
        item_t it;
        @(negedge clk);
        ev_irq_entry = irq; ev_call = call; ev_ret = ret;
        ev_reti = reti; opt_fast = fast;
        live_status = st; live_wreg = w; live_bank = b;
        if ((ret || reti) && fast) begin
            it.cyc = cyc + 1; it.st = m_st; it.w = m_w; it.b = m_b; it.req = req;
            exp_q.push_back(it);
        end
        if (irq || (call && fast)) begin
            m_st = st; m_w = w; m_b = b;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 5'h1F, 8'hFF, 4'hF, "R7");
    endtask

    // Monitor: compares each cycle's outputs with the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                item_t it;
                it = exp_q.pop_front();
                check(rest_valid === 1'b1, it.req,
                      $sformatf("valid actual=%b expected=1", rest_valid));
                check({rest_status, rest_wreg, rest_bank} === {it.st, it.w, it.b}, it.req,
                      $sformatf("data actual=%h/%h/%h expected=%h/%h/%h",
                                rest_status, rest_wreg, rest_bank, it.st, it.w, it.b));
                last_st = it.st; last_w = it.w; last_b = it.b;
            end else begin
                check(rest_valid === 1'b0, "R7",
                      $sformatf("valid actual=%b expected=0", rest_valid));
                check({rest_status, rest_wreg, rest_bank} === {last_st, last_w, last_b}, "R7",
                      $sformatf("held actual=%h/%h/%h expected=%h/%h/%h",
                                rest_status, rest_wreg, rest_bank, last_st, last_w, last_b));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(rest_valid === 1'b0 && {rest_status, rest_wreg, rest_bank} === '0, "R1",
              $sformatf("reset actual=%b/%h expected=0/0", rest_valid,
                        {rest_status, rest_wreg, rest_bank}));
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: fast return before any save restores zero
        drive(0, 0, 1, 0, 1, 5'h0A, 8'h55, 4'h3, "R1");
        idle(2);
        // R2: interrupt entry saves with fast low; R5: fast interrupt return
        drive(1, 0, 0, 0, 0, 5'h15, 8'hA5, 4'h9, "R2");
        idle(1);
        drive(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0, "R5");
        idle(2);
        // R3: fast call saves; R4: fast return
        drive(0, 1, 0, 0, 1, 5'h1F, 8'hFF, 4'hF, "R3");
        drive(0, 0, 1, 0, 1, 5'h01, 8'h02, 4'h3, "R4");
        idle(1);
        // R3: non-fast call does not save
        drive(0, 1, 0, 0, 0, 5'h0A, 8'h5A, 4'h5, "R3");
        drive(0, 0, 1, 0, 1, 5'h00, 8'h00, 4'h0, "R3");
        idle(1);
        // R6: non-fast returns have no effect
        drive(1, 0, 0, 0, 1, 5'h0C, 8'h3C, 4'h6, "R6");
        drive(0, 0, 1, 0, 0, 5'h11, 8'h11, 4'h1, "R6");
        drive(0, 0, 0, 1, 0, 5'h12, 8'h22, 4'h2, "R6");
        idle(1);
        drive(0, 0, 1, 0, 1, 5'h00, 8'h00, 4'h0, "R6");
        // R10: restores do not consume; back-to-back pulses (R7)
        drive(0, 0, 1, 0, 1, 5'h00, 8'h00, 4'h0, "R10");
        drive(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0, "R10");
        idle(2);
        // R8: nested interrupt overwrites
        drive(1, 0, 0, 0, 0, 5'h03, 8'h30, 4'h7, "R8");
        drive(1, 0, 0, 0, 0, 5'h1C, 8'hC3, 4'hE, "R8");
        drive(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0, "R8");
        idle(1);
        // R9: save and restore in the same cycle
        drive(1, 0, 0, 1, 1, 5'h0F, 8'h0F, 4'hA, "R9");
        drive(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0, "R9");
        idle(1);
        drive(0, 1, 1, 0, 1, 5'h10, 8'h80, 4'h8, "R9");
        drive(0, 0, 1, 0, 1, 5'h00, 8'h00, 4'h0, "R9");
        idle(3);
        check(exp_q.size() == 0, "R4",
              $sformatf("pending actual=%0d expected=0", exp_q.size()));
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule